// File: doc/BRIEF.md
# Trap delegation and vector unit

This block takes a trap request (cause code, interrupt flag, faulting PC, trap value and the privilege mode the hart was in) and decides which privilege level handles it. It then works out the handler address and raises one group of write strobes: the machine group (cause, EPC, trap value, MPP, MPIE, MIE cleared) or the supervisor group (cause, EPC, trap value, SPP, SPIE, SIE cleared). The registers behind those strobes live elsewhere. This block drives the values they take: `cause_out`, `epc_out`, `tval_out`, and `prev_mode` for the previous-privilege field.

The block holds three registers, reached through a small CSR port:
- the machine trap-vector register: base in bits [63:2], mode in bits [1:0], 0 for direct and 1 for vectored;
- the exception delegation mask;
- the interrupt delegation mask.

The supervisor trap-vector value uses the same format and arrives on an input. A trap taken in machine mode never goes down to supervisor. Trap vectoring covers ordinary traps only; reset and NMI entry addresses are not handled here.

A two-state sequencer runs each trap:
- **ST_IDLE** accepts a request. `trap_ready` is high. On transition *accept* (`trap_valid` high), the routing decision and all payload are captured, using the delegation state of that edge.
- **ST_COMMIT** lasts exactly one cycle. It presents the captured target and one strobe group. It always takes transition *retire* back to ST_IDLE.

Top module: `trap_router`

## Requirements
- R1: After reset, `trap_ready` is 1, `m_wr` and `s_wr` are 0, and reads return 0 for the following selects: vector (`csr_sel`=0), exception delegation (1), interrupt delegation (2), and the unused select (3).
- R2: A trap accepted while `trap_priv`=3 (machine) commits with `m_wr`=1 and `dest_mode`=3, whatever the delegation bits hold.
- R3: An exception from U (`trap_priv`=0) or S (1) whose exception delegation bit at index `trap_cause` is set commits with only `s_wr`=1 and `dest_mode`=1. In that cycle the outputs are: `cause_out` = {interrupt flag in bit 63, zeros, cause in the low bits}, `epc_out`/`tval_out` equal to the request, and `prev_mode` = `trap_priv`.
- R4: Only interrupt delegation bits 1, 5, 9 and 13 are writable; the rest read 0. An interrupt from U/S whose bit at index `trap_cause` is set goes to supervisor.
- R5: A trap from U/S whose relevant delegation bit is clear commits with only `m_wr`=1 and `dest_mode`=3.
- R6: Exception delegation bits 11 and 16 always read 0 and ignore writes; every other bit reads back what was written.
- R7: With vector mode 0 (direct), every trap to machine goes to the vector base with bits [1:0] cleared.
- R8: With vector mode 1 (vectored), a machine-bound interrupt goes to base + 4×cause and a machine-bound exception goes to base.
- R9: A vector-register write whose mode field is 2 or 3 updates the base but leaves the mode at its previous value.
- R10: A trap occupies exactly one commit cycle, in the cycle after acceptance. During that cycle exactly one of `m_wr`/`s_wr` is high and `trap_ready` is low. Both strobes are low in the following cycle.
- R11: For supervisor-bound traps, the target follows the direct/vectored rules of R7/R8 applied to `s_vec_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request |
| trap_ready | output | 1 | High in ST_IDLE; request accepted when both high |
| trap_intr | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 6 | Cause code |
| trap_priv | input | 2 | Mode at trap: 0 U, 1 S, 3 M |
| trap_epc | input | 64 | PC of the trapping instruction |
| trap_tval | input | 64 | Trap value |
| s_vec_base | input | 64 | Supervisor vector (base [63:2], mode [1:0]) |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 2 | 0 vector, 1 exception mask, 2 interrupt mask, 3 none |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data (combinational) |
| redirect_pc | output | 64 | Handler address, valid during commit |
| dest_mode | output | 2 | Destination mode, 1 S or 3 M |
| m_wr | output | 1 | Machine cause/EPC/tval/status-field strobe |
| s_wr | output | 1 | Supervisor cause/EPC/tval/status-field strobe |
| cause_out | output | 64 | Cause value to write |
| epc_out | output | 64 | EPC value to write |
| tval_out | output | 64 | Trap value to write |
| prev_mode | output | 2 | Previous mode for MPP/SPP |

## Verification
The assertions assume `trap_priv` never carries the reserved value 2. They also assume requests are held only while `trap_ready` could accept them, so every accept edge is a real trap. The stimulus meets both assumptions:
- It drives only 0, 1 or 3 on `trap_priv`.
- It raises `trap_valid` for exactly one accept edge per trap, then waits out the commit cycle before the next request.
- It changes CSR contents only between traps, so the delegation state seen at each accept edge is the one the scoreboard used.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        SEL_VEC     = 2'd0,
        SEL_EXC_DLG = 2'd1,
        SEL_INT_DLG = 2'd2,
        SEL_NONE    = 2'd3
    } csr_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } state_e;
endpackage

// File: rtl/trap_router_regs.sv
module trap_router_regs
    import trap_router_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter bit          VECTORED_EN = 1'b1,
    parameter logic [63:0] EXC_FIXED0  = 64'h0001_0800,
    parameter logic [63:0] INT_WMASK   = 64'h0000_2222,
    parameter logic [63:0] RESET_BASE  = 64'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] m_vec,
    output logic [XLEN-1:0] exc_dlg,
    output logic [XLEN-1:0] int_dlg
);
    localparam logic [XLEN-1:0] EXC_WMASK = ~EXC_FIXED0[XLEN-1:0];
    localparam logic [XLEN-1:0] INT_MASK  = INT_WMASK[XLEN-1:0];

    csr_sel_e        sel;
    logic [XLEN-3:0] base_q;
    logic [1:0]      mode_q;

    assign sel = csr_sel_e'(csr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= RESET_BASE[XLEN-1:2];
            exc_dlg <= '0;
            int_dlg <= '0;
        end else if (csr_we) begin
            unique case (sel)
                SEL_VEC:     base_q  <= csr_wdata[XLEN-1:2];
                SEL_EXC_DLG: exc_dlg <= csr_wdata & EXC_WMASK;
                SEL_INT_DLG: int_dlg <= csr_wdata & INT_MASK;
                SEL_NONE:    ;
            endcase
        end
    end

    generate
        if (VECTORED_EN) begin : g_mode_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mode_q <= 2'd0;
                end else if (csr_we && sel == SEL_VEC && !csr_wdata[1]) begin
                    mode_q <= csr_wdata[1:0];
                end
            end
        end else begin : g_mode_direct
            assign mode_q = 2'd0;
        end
    endgenerate

    assign m_vec = {base_q, mode_q};

    always_comb begin
        unique case (sel)
            SEL_VEC:     csr_rdata = m_vec;
            SEL_EXC_DLG: csr_rdata = exc_dlg;
            SEL_INT_DLG: csr_rdata = int_dlg;
            SEL_NONE:    csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trap_router_decide.sv
module trap_router_decide
    import trap_router_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic [1:0]         trap_priv,
    input  logic               trap_intr,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    exc_dlg,
    input  logic [XLEN-1:0]    int_dlg,
    input  logic [XLEN-1:0]    m_vec,
    input  logic [XLEN-1:0]    s_vec,
    output logic               to_super,
    output logic [XLEN-1:0]    target
);
    function automatic logic [XLEN-1:0] vec_target(
        input logic [XLEN-1:0]    vec,
        input logic               intr,
        input logic [CAUSE_W-1:0] cause
    );
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] offs;
        base = {vec[XLEN-1:2], 2'b00};
        offs = (intr && vec[1:0] == 2'd1) ? XLEN'({cause, 2'b00}) : '0;
        return base + offs;
    endfunction

    logic dlg_bit;

    always_comb begin
        dlg_bit  = trap_intr ? int_dlg[trap_cause] : exc_dlg[trap_cause];
        to_super = (priv_e'(trap_priv) != PRIV_M) && dlg_bit;
        target   = vec_target(to_super ? s_vec : m_vec, trap_intr, trap_cause);
    end
endmodule

// File: rtl/trap_router_seq.sv
module trap_router_seq
    import trap_router_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    output logic               trap_ready,
    input  logic               trap_intr,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [1:0]         trap_priv,
    input  logic [XLEN-1:0]    trap_epc,
    input  logic [XLEN-1:0]    trap_tval,
    input  logic               to_super,
    input  logic [XLEN-1:0]    target,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         dest_mode,
    output logic               m_wr,
    output logic               s_wr,
    output logic [XLEN-1:0]    cause_out,
    output logic [XLEN-1:0]    epc_out,
    output logic [XLEN-1:0]    tval_out,
    output logic [1:0]         prev_mode
);
    state_e state_q;
    state_e state_d;
    logic   accept;
    logic   super_q;

    assign accept = (state_q == ST_IDLE) && trap_valid;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            super_q     <= 1'b0;
            redirect_pc <= '0;
            cause_out   <= '0;
            epc_out     <= '0;
            tval_out    <= '0;
            prev_mode   <= 2'd0;
        end else if (accept) begin
            super_q     <= to_super;
            redirect_pc <= target;
            cause_out   <= {trap_intr, (XLEN-1)'(trap_cause)};
            epc_out     <= trap_epc;
            tval_out    <= trap_tval;
            prev_mode   <= trap_priv;
        end
    end

    always_comb begin
        trap_ready = (state_q == ST_IDLE);
        m_wr       = (state_q == ST_COMMIT) && !super_q;
        s_wr       = (state_q == ST_COMMIT) && super_q;
        dest_mode  = super_q ? PRIV_S : PRIV_M;
    end
endmodule

// File: rtl/trap_router.sv
module trap_router #(
    parameter int          XLEN        = 64,
    parameter int          CAUSE_W     = 6,
    parameter bit          VECTORED_EN = 1'b1,
    parameter logic [63:0] EXC_FIXED0  = 64'h0001_0800,
    parameter logic [63:0] INT_WMASK   = 64'h0000_2222,
    parameter logic [63:0] RESET_BASE  = 64'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    output logic               trap_ready,
    input  logic               trap_intr,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [1:0]         trap_priv,
    input  logic [XLEN-1:0]    trap_epc,
    input  logic [XLEN-1:0]    trap_tval,
    input  logic [XLEN-1:0]    s_vec_base,
    input  logic               csr_we,
    input  logic [1:0]         csr_sel,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         dest_mode,
    output logic               m_wr,
    output logic               s_wr,
    output logic [XLEN-1:0]    cause_out,
    output logic [XLEN-1:0]    epc_out,
    output logic [XLEN-1:0]    tval_out,
    output logic [1:0]         prev_mode
);
    logic [XLEN-1:0] m_vec;
    logic [XLEN-1:0] exc_dlg;
    logic [XLEN-1:0] int_dlg;
    logic            to_super;
    logic [XLEN-1:0] target;

    trap_router_regs #(
        .XLEN(XLEN), .VECTORED_EN(VECTORED_EN), .EXC_FIXED0(EXC_FIXED0),
        .INT_WMASK(INT_WMASK), .RESET_BASE(RESET_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .m_vec(m_vec),
        .exc_dlg(exc_dlg), .int_dlg(int_dlg)
    );

    trap_router_decide #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_decide (
        .trap_priv(trap_priv), .trap_intr(trap_intr), .trap_cause(trap_cause),
        .exc_dlg(exc_dlg), .int_dlg(int_dlg), .m_vec(m_vec), .s_vec(s_vec_base),
        .to_super(to_super), .target(target)
    );

    trap_router_seq #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
        .trap_intr(trap_intr), .trap_cause(trap_cause), .trap_priv(trap_priv),
        .trap_epc(trap_epc), .trap_tval(trap_tval), .to_super(to_super),
        .target(target), .redirect_pc(redirect_pc), .dest_mode(dest_mode),
        .m_wr(m_wr), .s_wr(s_wr), .cause_out(cause_out), .epc_out(epc_out),
        .tval_out(tval_out), .prev_mode(prev_mode)
    );
endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic            trap_ready,
    input logic [1:0]      trap_priv,
    input logic            m_wr,
    input logic            s_wr,
    input logic [1:0]      dest_mode,
    input logic [1:0]      csr_sel,
    input logic [XLEN-1:0] csr_rdata
);
    // R10
    commit_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_ready) |=> (m_wr || s_wr));

    // R10
    strobes_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_wr, s_wr}));

    // R10
    commit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr || s_wr) |-> (!trap_ready) ##1 !(m_wr || s_wr));

    // R2
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_ready && trap_priv == 2'd3) |=> (m_wr && dest_mode == 2'd3));

    // R3
    super_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_wr |-> dest_mode == 2'd1);

    // R6
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == 2'd1) |-> (!csr_rdata[11] && !csr_rdata[16]));

    // R9
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == 2'd0) |-> !csr_rdata[1]);
endmodule

bind trap_router trap_router_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_priv(trap_priv), .m_wr(m_wr), .s_wr(s_wr), .dest_mode(dest_mode),
    .csr_sel(csr_sel), .csr_rdata(csr_rdata)
);

// File: tb/trap_router_bench.sv
module trap_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic        trap_ready;
    logic        trap_intr = 1'b0;
    logic [5:0]  trap_cause = '0;
    logic [1:0]  trap_priv = '0;
    logic [63:0] trap_epc = '0;
    logic [63:0] trap_tval = '0;
    logic [63:0] s_vec_base = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [63:0] redirect_pc;
    logic [1:0]  dest_mode;
    logic        m_wr;
    logic        s_wr;
    logic [63:0] cause_out;
    logic [63:0] epc_out;
    logic [63:0] tval_out;
    logic [1:0]  prev_mode;

    typedef struct {
        logic        sup;
        logic [63:0] pc;
        logic [63:0] cause;
        logic [63:0] epc;
        logic [63:0] tval;
        logic [1:0]  prev;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   ended = 0;

    logic [63:0] tvec_m = '0;
    logic [63:0] edeleg_m = '0;
    logic [63:0] ideleg_m = '0;

    always #10 clk = ~clk;

    trap_router u_trap_router (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
        .trap_intr(trap_intr), .trap_cause(trap_cause), .trap_priv(trap_priv),
        .trap_epc(trap_epc), .trap_tval(trap_tval), .s_vec_base(s_vec_base),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .redirect_pc(redirect_pc), .dest_mode(dest_mode),
        .m_wr(m_wr), .s_wr(s_wr), .cause_out(cause_out), .epc_out(epc_out),
        .tval_out(tval_out), .prev_mode(prev_mode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per commit cycle.
    always @(negedge clk) begin
        if (rst_n && (m_wr || s_wr)) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected commit", {62'd0, m_wr, s_wr}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(s_wr == e.sup && m_wr == !e.sup, e.req, "strobes",
                      {62'd0, m_wr, s_wr}, {62'd0, !e.sup, e.sup});
                check(dest_mode == (e.sup ? 2'd1 : 2'd3), e.req, "dest_mode",
                      64'(dest_mode), e.sup ? 64'd1 : 64'd3);
                check(redirect_pc == e.pc, e.req, "redirect_pc", redirect_pc, e.pc);
                check(cause_out == e.cause, e.req, "cause_out", cause_out, e.cause);
                check(epc_out == e.epc && tval_out == e.tval, e.req, "epc/tval",
                      epc_out ^ tval_out, e.epc ^ e.tval);
                check(prev_mode == e.prev, e.req, "prev_mode", 64'(prev_mode), 64'(e.prev));
            end
        end
    end

    task automatic wr_csr(input logic [1:0] sel, input logic [63:0] data);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(posedge clk); @(negedge clk);
        csr_we = 1'b0;
        case (sel)
            2'd0: begin
                tvec_m[63:2] = data[63:2];
                if (data[1:0] < 2'd2) tvec_m[1:0] = data[1:0];
            end
            2'd1: edeleg_m = data & ~(64'h1 << 11) & ~(64'h1 << 16);
            2'd2: ideleg_m = data & 64'h2222;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [63:0] exp, input string req);
        csr_sel = sel;
        #1;
        check(csr_rdata == exp, req, "csr_rdata", csr_rdata, exp);
    endtask

    task automatic do_trap(input logic intr, input logic [5:0] cause, input logic [1:0] priv,
                           input logic [63:0] epc, input logic [63:0] tval, input string req);
        exp_t e;
        logic dlg;
        logic [63:0] vec;
        dlg   = (priv != 2'd3) && (intr ? ideleg_m[cause] : edeleg_m[cause]);
        vec   = dlg ? s_vec_base : tvec_m;
        e.sup = dlg;
        e.pc  = {vec[63:2], 2'b00} + ((vec[1:0] == 2'd1 && intr) ? 64'(cause) * 64'd4 : 64'd0);
        e.cause = {intr, 57'd0, cause};
        e.epc = epc; e.tval = tval; e.prev = priv; e.req = req;
        exp_q.push_back(e);
        trap_valid = 1'b1; trap_intr = intr; trap_cause = cause;
        trap_priv = priv; trap_epc = epc; trap_tval = tval;
        @(posedge clk); @(negedge clk);
        trap_valid = 1'b0;
        check(trap_ready == 1'b0, "R10", "ready during commit", 64'(trap_ready), 64'd0);
        @(negedge clk);
        check(trap_ready && !m_wr && !s_wr, "R10", "idle after commit",
              {61'd0, trap_ready, m_wr, s_wr}, 64'd4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WATCHDOG", "timeout", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(trap_ready && !m_wr && !s_wr, "R1", "reset outputs",
              {61'd0, trap_ready, m_wr, s_wr}, 64'd4);
        rd_chk(2'd0, 64'd0, "R1");
        rd_chk(2'd1, 64'd0, "R1");
        rd_chk(2'd2, 64'd0, "R1");
        rd_chk(2'd3, 64'd0, "R1");

        // R6 fixed-zero exception delegation bits
        wr_csr(2'd1, '1);
        rd_chk(2'd1, ~(64'h1 << 11) & ~(64'h1 << 16), "R6");
        // R4 interrupt delegation writable set
        wr_csr(2'd2, '1);
        rd_chk(2'd2, 64'h2222, "R4");

        // R7 direct mode
        wr_csr(2'd0, 64'h8000_0102);
        rd_chk(2'd0, 64'h8000_0100, "R9");
        wr_csr(2'd0, 64'h8000_0100);
        rd_chk(2'd0, 64'h8000_0100, "R7");
        s_vec_base = 64'h4000_0201;

        // R2 machine trap stays in machine despite delegation
        do_trap(1'b0, 6'd2, 2'd3, 64'h1000, 64'h11, "R2");
        // R3 delegated exception from U
        do_trap(1'b0, 6'd2, 2'd0, 64'h2004, 64'h22, "R3");
        // R11 delegated interrupt from S with vectored supervisor base
        do_trap(1'b1, 6'd5, 2'd1, 64'h3008, 64'h0, "R11");
        // R5 non-delegable interrupt, R7 direct target
        do_trap(1'b1, 6'd7, 2'd1, 64'h400c, 64'h0, "R7");

        // R8 vectored mode
        wr_csr(2'd0, 64'h8000_0001);
        rd_chk(2'd0, 64'h8000_0001, "R8");
        do_trap(1'b1, 6'd7, 2'd0, 64'h5000, 64'h0, "R8");
        // R6 cause 11 cannot delegate, goes to M base
        do_trap(1'b0, 6'd11, 2'd0, 64'h6000, 64'h33, "R6");

        // R9 reserved mode value ignored, base updated
        wr_csr(2'd0, 64'h9000_0003);
        rd_chk(2'd0, 64'h9000_0001, "R9");
        wr_csr(2'd0, 64'h9000_0002);
        rd_chk(2'd0, 64'h9000_0001, "R9");

        // R2 delegated interrupt bit 9 from M stays M, vectored
        do_trap(1'b1, 6'd9, 2'd3, 64'h7000, 64'h0, "R2");
        // R4 interrupt 9 from U goes to S
        do_trap(1'b1, 6'd9, 2'd0, 64'h7100, 64'h0, "R4");

        // R5 cleared delegation sends to M
        wr_csr(2'd1, 64'd0);
        rd_chk(2'd1, 64'd0, "R5");
        do_trap(1'b0, 6'd2, 2'd1, 64'h8000, 64'h44, "R5");

        @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending items", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule